// File: doc/BRIEF.md
# Auto-Reload Baud and Clock-Out Timer

This block is a reloading up-counter. Its width is a parameter and is 16 bits by default. When it passes its all-ones value it loads a programmable reload value and continues counting. The period between overflows therefore depends on how far the reload value sits below the wrap point. The same overflow stream serves three consumers:

- An overflow flag, used in plain timer or event-counter use.
- A single-cycle baud tick for a serial port. The tick rate is the clock frequency divided by 32 × (2^W − reload).
- A 50% duty clock-out pin. Its rate is the clock frequency divided by 4 × (2^W − reload).

The counter's step rate depends on the mode. Plain timer use steps once every twelve clocks. Counter use steps on falling edges of an input pin. Baud or clock-out use steps every second clock.

An external pin with its own enable sets an edge flag on each falling edge. Outside baud use, that same edge also forces a reload of the counter. Software loads the counter and the reload register through a small write port. The write port works only while the timer is stopped.

Top module: `autoreload_timer`

## Requirements
- R1: After reset the count and the reload value are 0. The overflow flag, the edge flag, the clock-out pin and the baud tick are all 0.
- R2: A write (regWrEn=1) while runEn=0 loads regWrData into the counter when regSel=0, or into the reload register when regSel=1. A write while runEn=1 changes neither register.
- R3: In slow timer use the counter advances by one every SLOW_DIV (12) clocks while runEn=1. Slow timer use means cntSel=0, rxBaudSel=0, txBaudSel=0 and clkOutEn=0.
- R4: In event-counter use the counter advances by one for each 1-to-0 transition of countPin while runEn=1. Event-counter use means cntSel=1 with both baud selects at 0.
- R5: Fast use is active when rxBaudSel or txBaudSel is 1, or when clkOutEn=1 together with cntSel=0. In fast use the counter advances every FAST_DIV (2) clocks while runEn=1.
- R6: A step taken from the all-ones count loads the reload value on that same clock edge.
- R7: An overflow sets ovfFlag only outside fast use. ovfFlag stays set until ovfClr is applied. A set in the same cycle as ovfClr wins over the clear.
- R8: clkOut toggles on every overflow while clkOutEn=1 and cntSel=0. In all other cases clkOut holds its level.
- R9: In baud use (rxBaudSel or txBaudSel is 1), baudTick is a one-clock pulse. It appears in the cycle after every TICK_DIV-th (16) overflow. The overflow divider is cleared whenever baud use is off.
- R10: A 1-to-0 transition of extPin while extEn=1 sets extFlag in every mode. extFlag is cleared by extClr, and a set wins over a clear.
- R11: Outside baud use, that extPin event also reloads the counter, with priority over a step. The reloading edge is not counted as an overflow. In baud use the event does not touch the counter.
- R12: While runEn=0 the counter does not step, and the prescaler restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable; also closes the write port |
| cntSel | input | 1 | 1 = count countPin edges, 0 = timer |
| rxBaudSel | input | 1 | Receive baud use select |
| txBaudSel | input | 1 | Transmit baud use select |
| clkOutEn | input | 1 | Clock-out enable |
| countPin | input | 1 | Event input for counter use |
| extEn | input | 1 | Enables the external edge function |
| extPin | input | 1 | External edge pin |
| ovfClr | input | 1 | Clears ovfFlag |
| extClr | input | 1 | Clears extFlag |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = counter, 1 = reload register |
| regWrData | input | CNT_W | Write data |
| countOut | output | CNT_W | Current count |
| baudTick | output | 1 | Baud tick pulse |
| clkOut | output | 1 | Clock-out pin |
| ovfFlag | output | 1 | Overflow flag |
| extFlag | output | 1 | External edge flag |

## Verification
The bench builds the block with CNT_W=8 and TICK_DIV=4. With these values a reload near the top of the range gives an overflow every few dozen clocks. A baud tick then follows every four overflows. This brings many wraps, several ticks and many clock-out toggles into a few thousand cycles. The remaining cases are also reached in those runs: mode changes in the middle of a count, external edges in baud and non-baud use, and writes made while running.

// File: rtl/art_pkg.sv
package art_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic step;       // advance counter by one
    logic extReload;  // external edge forces reload
    logic extSet;     // external edge sets extFlag
    logic wrCount;    // load counter from write port
    logic wrReload;   // load reload register from write port
    logic ovfFlagEn;  // overflow may set ovfFlag
    logic tickEn;     // overflow feeds baud divider
    logic toggleEn;   // overflow toggles clkOut
  } artStrobe_t;
endpackage

// File: rtl/art_ctrl.sv
module art_ctrl
  import art_pkg::*;
#(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       cntSel,
  input  logic       rxBaudSel,
  input  logic       txBaudSel,
  input  logic       clkOutEn,
  input  logic       countPin,
  input  logic       extEn,
  input  logic       extPin,
  input  logic       regWrEn,
  input  logic       regSel,
  output artStrobe_t strobe
);
  localparam int PS_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PS_W-1:0] SLOW_LAST = PS_W'(SLOW_DIV - 1);
  localparam logic [PS_W-1:0] FAST_LAST = PS_W'(FAST_DIV - 1);

  logic baudMode, toggleMode, fastMode, edgeMode;
  logic countPinQ, extPinQ;
  logic countFall, extFall;
  logic [PS_W-1:0] psQ;
  logic [PS_W-1:0] psLast;
  logic psWrap;

  always_comb begin
    baudMode   = rxBaudSel | txBaudSel;
    toggleMode = clkOutEn & ~cntSel;
    fastMode   = baudMode | toggleMode;
    edgeMode   = cntSel & ~fastMode;
    psLast     = fastMode ? FAST_LAST : SLOW_LAST;
    psWrap     = (psQ >= psLast);
    countFall  = countPinQ & ~countPin;
    extFall    = extPinQ & ~extPin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countPinQ <= 1'b1;
      extPinQ   <= 1'b1;
    end else begin
      countPinQ <= countPin;
      extPinQ   <= extPin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             psQ <= '0;
    else if (!runEn || edgeMode || psWrap) psQ <= '0;
    else                                   psQ <= psQ + 1'b1;
  end

  always_comb begin
    strobe           = '0;
    strobe.step      = runEn & (edgeMode ? countFall : psWrap);
    strobe.extSet    = extEn & extFall;
    strobe.extReload = extEn & extFall & ~baudMode;
    strobe.wrCount   = regWrEn & ~runEn & ~regSel;
    strobe.wrReload  = regWrEn & ~runEn & regSel;
    strobe.ovfFlagEn = ~fastMode;
    strobe.tickEn    = baudMode;
    strobe.toggleEn  = toggleMode;
  end
endmodule

// File: rtl/art_datapath.sv
module art_datapath
  import art_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  artStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic             ovfClr,
  input  logic             extClr,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] reloadQ,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             clkOut,
  output logic             baudTick
);
  localparam int TICK_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  logic ovfEvt;
  logic [TICK_W-1:0] tickQ;

  always_comb
    ovfEvt = strobe.step & ~strobe.extReload & ~strobe.wrCount & (countQ == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 countQ <= '0;
    else if (strobe.wrCount)   countQ <= wrData;
    else if (strobe.extReload) countQ <= reloadQ;
    else if (ovfEvt)           countQ <= reloadQ;
    else if (strobe.step)      countQ <= countQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                reloadQ <= '0;
    else if (strobe.wrReload) reloadQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      extFlag <= 1'b0;
    end else begin
      if (ovfEvt && strobe.ovfFlagEn) ovfFlag <= 1'b1;
      else if (ovfClr)                ovfFlag <= 1'b0;
      if (strobe.extSet)              extFlag <= 1'b1;
      else if (extClr)                extFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           clkOut <= 1'b0;
    else if (ovfEvt && strobe.toggleEn)  clkOut <= ~clkOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ    <= '0;
      baudTick <= 1'b0;
    end else begin
      baudTick <= 1'b0;
      if (!strobe.tickEn) begin
        tickQ <= '0;
      end else if (ovfEvt) begin
        if (tickQ == TICK_LAST) begin
          tickQ    <= '0;
          baudTick <= 1'b1;
        end else begin
          tickQ <= tickQ + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/autoreload_timer.sv
module autoreload_timer
  import art_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2,
  parameter int TICK_DIV = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             cntSel,
  input  logic             rxBaudSel,
  input  logic             txBaudSel,
  input  logic             clkOutEn,
  input  logic             countPin,
  input  logic             extEn,
  input  logic             extPin,
  input  logic             ovfClr,
  input  logic             extClr,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] countOut,
  output logic             baudTick,
  output logic             clkOut,
  output logic             ovfFlag,
  output logic             extFlag
);
  artStrobe_t strobe;
  logic [CNT_W-1:0] reloadVal;

  art_ctrl #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cntSel(cntSel),
    .rxBaudSel(rxBaudSel), .txBaudSel(txBaudSel), .clkOutEn(clkOutEn),
    .countPin(countPin), .extEn(extEn), .extPin(extPin),
    .regWrEn(regWrEn), .regSel(regSel), .strobe(strobe)
  );

  art_datapath #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .ovfClr(ovfClr), .extClr(extClr), .countQ(countOut), .reloadQ(reloadVal),
    .ovfFlag(ovfFlag), .extFlag(extFlag), .clkOut(clkOut), .baudTick(baudTick)
  );
endmodule

// File: rtl/art_checker.sv
module art_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             regWrEn,
  input logic             extEn,
  input logic             cntSel,
  input logic             rxBaudSel,
  input logic             txBaudSel,
  input logic             clkOutEn,
  input logic [CNT_W-1:0] countOut,
  input logic [CNT_W-1:0] reloadVal,
  input logic             baudTick,
  input logic             clkOut,
  input logic             ovfFlag,
  input logic             extFlag
);
  // R2
  reload_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(runEn) |-> $stable(reloadVal));

  // R12
  stopped_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!runEn && !regWrEn && !extEn) |-> $stable(countOut));

  // R7
  fast_no_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(!(rxBaudSel || txBaudSel || (clkOutEn && !cntSel))));

  // R8
  clkout_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(clkOut) |-> $past(clkOutEn && !cntSel));

  // R9
  tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

  // R9
  tick_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> $past(rxBaudSel || txBaudSel));

  // R10
  ext_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extFlag) |-> $past(extEn));
endmodule

bind autoreload_timer art_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .regWrEn(regWrEn), .extEn(extEn),
  .cntSel(cntSel), .rxBaudSel(rxBaudSel), .txBaudSel(txBaudSel),
  .clkOutEn(clkOutEn), .countOut(countOut), .reloadVal(reloadVal),
  .baudTick(baudTick), .clkOut(clkOut), .ovfFlag(ovfFlag), .extFlag(extFlag)
);

// File: tb/autoreload_timer_tb.sv
module autoreload_timer_tb;
  localparam int CNT_W    = 8;
  localparam int SLOW_DIV = 12;
  localparam int FAST_DIV = 2;
  localparam int TICK_DIV = 4;
  localparam int MAXV     = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 0, cntSel = 0, rxBaudSel = 0, txBaudSel = 0, clkOutEn = 0;
  logic countPin = 1, extEn = 0, extPin = 1, ovfClr = 0, extClr = 0;
  logic regWrEn = 0, regSel = 0;
  logic [CNT_W-1:0] regWrData = '0;
  logic [CNT_W-1:0] countOut;
  logic baudTick, clkOut, ovfFlag, extFlag;

  always #2.5 clk = ~clk;

  autoreload_timer #(.CNT_W(CNT_W), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV),
                     .TICK_DIV(TICK_DIV)) u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cntSel(cntSel),
    .rxBaudSel(rxBaudSel), .txBaudSel(txBaudSel), .clkOutEn(clkOutEn),
    .countPin(countPin), .extEn(extEn), .extPin(extPin), .ovfClr(ovfClr),
    .extClr(extClr), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .countOut(countOut), .baudTick(baudTick), .clkOut(clkOut),
    .ovfFlag(ovfFlag), .extFlag(extFlag)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference state
  int mCount, mReload, mPs, mTick;
  bit mOvf, mExt, mClk, mBaud, mCpPrev, mEpPrev;

  always @(posedge clk) begin
    bit fast, baud, tog, step, cFall, eFall, eSet, eRel, ovf;
    int lim;
    if (!rstN) begin
      mCount = 0; mReload = 0; mPs = 0; mTick = 0;
      mOvf = 0; mExt = 0; mClk = 0; mBaud = 0; mCpPrev = 1; mEpPrev = 1;
    end else begin
      baud  = rxBaudSel || txBaudSel;
      tog   = clkOutEn && !cntSel;
      fast  = baud || tog;
      cFall = mCpPrev && !countPin;
      eFall = mEpPrev && !extPin;
      mCpPrev = countPin;
      mEpPrev = extPin;
      step = 0;
      if (!runEn) mPs = 0;
      else if (cntSel && !fast) begin step = cFall; mPs = 0; end
      else begin
        lim = fast ? FAST_DIV : SLOW_DIV;
        if (mPs >= lim - 1) begin step = 1; mPs = 0; end
        else mPs = mPs + 1;
      end
      eSet = extEn && eFall;
      eRel = eSet && !baud;
      ovf  = step && !eRel && mCount == MAXV;
      if (regWrEn && !runEn && !regSel) mCount = int'(regWrData);
      else if (eRel || ovf) mCount = mReload;
      else if (step) mCount = mCount + 1;
      if (regWrEn && !runEn && regSel) mReload = int'(regWrData);
      if (ovf && !fast) mOvf = 1; else if (ovfClr) mOvf = 0;
      if (eSet) mExt = 1; else if (extClr) mExt = 0;
      if (ovf && tog) mClk = !mClk;
      mBaud = 0;
      if (!baud) mTick = 0;
      else if (ovf) begin
        if (mTick == TICK_DIV - 1) begin mTick = 0; mBaud = 1; end
        else mTick = mTick + 1;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(curReq, "countOut", int'(countOut), mCount);
      check(curReq, "ovfFlag", int'(ovfFlag), int'(mOvf));
      check(curReq, "extFlag", int'(extFlag), int'(mExt));
      check(curReq, "clkOut", int'(clkOut), int'(mClk));
      check(curReq, "baudTick", int'(baudTick), int'(mBaud));
    end
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, int data);
    @(negedge clk);
    regWrEn = 1; regSel = sel; regWrData = CNT_W'(data);
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic extFallPulse();
    @(negedge clk); extPin = 0;
    idle(3);
    extPin = 1;
    idle(3);
  endtask

  initial begin
    idle(3);
    rstN = 1;
    @(negedge clk);
    // R1 direct reset check
    check("R1", "count at reset", int'(countOut), 0);
    check("R1", "flags at reset", int'({ovfFlag, extFlag, clkOut, baudTick}), 0);

    curReq = "R2";
    wr(0, 'hF8);
    wr(1, 'hF0);
    idle(2);

    curReq = "R3/R6/R7";
    @(negedge clk); runEn = 1;
    idle(260);

    curReq = "R2";
    wr(1, 'h10);
    wr(0, 'h20);
    idle(220);

    curReq = "R7";
    @(negedge clk); ovfClr = 1;
    @(negedge clk); ovfClr = 0;
    idle(5);

    curReq = "R12";
    @(negedge clk); runEn = 0;
    idle(30);
    curReq = "R2";
    wr(0, 'hFC);

    curReq = "R4/R6";
    @(negedge clk); cntSel = 1; runEn = 1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); countPin = 0;
      idle(2);
      countPin = 1;
      idle(2);
    end

    curReq = "R5/R9";
    @(negedge clk); cntSel = 0; rxBaudSel = 1;
    idle(700);

    curReq = "R10/R11";
    extEn = 1;
    extFallPulse();
    @(negedge clk); extClr = 1;
    @(negedge clk); extClr = 0;
    idle(40);

    curReq = "R8";
    @(negedge clk); rxBaudSel = 0; clkOutEn = 1;
    idle(300);
    @(negedge clk); txBaudSel = 1;
    idle(400);
    @(negedge clk); cntSel = 1;
    idle(100);

    curReq = "R11";
    @(negedge clk); txBaudSel = 0; clkOutEn = 0; cntSel = 0;
    idle(50);
    extFallPulse();
    extFallPulse();
    @(negedge clk); extEn = 0;
    extFallPulse();
    idle(50);

    curReq = "R12";
    @(negedge clk); runEn = 0;
    idle(40);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule